// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Transmitter

This block turns a short packet into the differential line states of a low-speed serial bus, the kind used by USB. A start strobe comes with a byte count. The count includes a sync byte, which the block produces itself. The block then fetches the payload bytes one at a time through a single-cycle read strobe and sends every byte least significant bit first. The line is NRZI encoded, and a stuffed bit is inserted after every run of six ones. At the end the block drives the end-of-packet pattern and lets go of the bus.

Before the drivers are enabled, the line outputs are already set to the idle (J) state. A handshake mode sends only the sync byte and one PID, either ACK or NAK, and reads no payload. A device address offered on an input takes effect, shifted left by one, only when a data packet ends. Handshakes never change it. When the bus is released, the block raises a one-cycle done pulse and a one-cycle pulse that clears any receive-start event that its own traffic caused.

Top module: `ls_pkt_tx`

## Requirements
- R1: After reset, `oe`, `dp`, `dm`, `busy`, `done` and `rx_clr` are all 0.
- R2: The cycle after a start is accepted, the lines show J (`dp`=0, `dm`=1) with `oe` still 0. `oe` rises in the next cycle.
- R3: The first byte on the line is 0x80, sent LSb first. The first driven bit is therefore K.
- R4: J is `dp`=0/`dm`=1 and K is `dp`=1/`dm`=0. The line starts at J. A 0 bit toggles the line and a 1 bit keeps it.
- R5: After six consecutive 1 bits a 0 bit is inserted. The run is counted across byte boundaries, and a stuffed bit also follows a run that ends the last byte.
- R6: Every bit, stuffed or not, occupies exactly CLKS_PER_BIT (default 11) clock cycles.
- R7: `byte_cnt` counts the sync byte. Values below 2 act as 2 and values above 12 act as 12. A data packet produces exactly `byte_cnt`-1 `byte_rd` pulses, and `byte_data` is taken in the same cycle as each pulse.
- R8: After the last bit, the block drives SE0 (`dp`=`dm`=0, `oe`=1) for two bit times and J for one bit time. It then drops `oe` with both lines at 0.
- R9: When `hs_mode`=1, the packet is the sync byte plus the PID 0xD2 (ACK, `hs_nak`=0) or 0x5A (NAK, `hs_nak`=1), with no `byte_rd` pulse.
- R10: `dev_addr` becomes {`new_addr`,0} in the cycle the bus is released after a data packet. It keeps its value after a handshake and changes at no other time.
- R11: `busy` is 1 from the cycle after a start until the release. `done` and `rx_clr` pulse for one cycle at the release, and a start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (11 cycles per bit by default) |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (sampled only when idle) |
| byte_cnt | input | 4 | Byte count including sync |
| hs_mode | input | 1 | Send a handshake PID only |
| hs_nak | input | 1 | Handshake PID select: 0 ACK, 1 NAK |
| byte_rd | output | 1 | Payload fetch strobe |
| byte_data | input | 8 | Payload byte, valid while `byte_rd` is high |
| new_addr | input | 7 | Pending device address |
| dev_addr | output | 8 | Committed address, shifted left by one |
| dp | output | 1 | Positive line level |
| dm | output | 1 | Negative line level |
| oe | output | 1 | Line driver enable |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle release pulse |
| rx_clr | output | 1 | Clear pulse for a self-caused receive-start event |

## Verification
The bench compares every cycle of the line against a bit-level model, so that stuffing is tested where it matters most:
- A run of ones that crosses a byte boundary must be stuffed. A design that resets its run counter per byte would miss that stuffed bit.
- A run of ones that closes the final byte must be stuffed. A design that goes straight to SE0 would drop the last stuffed bit.
- The end-of-packet pattern is checked by length. An SE0 or trailing J that is one bit short or long shows up as a trace of the wrong length.

The bench also covers the behaviour around the payload:
- It checks clamping of `byte_cnt` and that handshakes make no payload fetch.
- It checks that a handshake leaves the address untouched. A design that commits the address on every release fails there.
- It pulses start in the middle of a packet, which a design that restarts on it would turn into a corrupted trace.

// File: rtl/ls_tx_pkg.sv
package ls_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRESET,
      ST_BITS,
      ST_SE0,
      ST_JEND
   } tx_state_e;

   localparam logic [7:0] SYNC_BYTE = 8'h80;
   localparam logic [7:0] PID_ACK   = 8'hD2;
   localparam logic [7:0] PID_NAK   = 8'h5A;
   localparam int         STUFF_RUN = 6;
endpackage

// File: rtl/ls_tx_bit_timer.sv
module ls_tx_bit_timer #(
   parameter int CLKS_PER_BIT = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
   localparam logic [TW-1:0] LAST = TW'(CLKS_PER_BIT - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/ls_tx_line_coder.sv
module ls_tx_line_coder #(
   parameter int RUN_LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic step,
   input  logic data_bit,
   output logic stuff_due,
   output logic line_k
);
   localparam int RW = $clog2(RUN_LEN + 1);

   logic [RW-1:0] ones;

   assign stuff_due = (ones == RW'(RUN_LEN));

   always_ff @(posedge clk) begin
      if (!rst_n || init) begin
         ones   <= '0;
         line_k <= 1'b0;
      end else if (step) begin
         if (stuff_due) begin
            line_k <= ~line_k;
            ones   <= '0;
         end else if (data_bit) begin
            ones   <= ones + 1'b1;
         end else begin
            line_k <= ~line_k;
            ones   <= '0;
         end
      end
   end
endmodule

// File: rtl/ls_tx_byte_feed.sv
module ls_tx_byte_feed #(
   parameter int MAX_BYTES = 12,
   localparam int CW = $clog2(MAX_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          hs,
   input  logic [7:0]    pid,
   input  logic [CW-1:0] left_init,
   input  logic          consume,
   input  logic [7:0]    byte_data,
   output logic          data_bit,
   output logic          all_sent,
   output logic          byte_rd
);
   import ls_tx_pkg::*;

   logic [7:0]    shreg;
   logic [2:0]    bit_idx;
   logic [CW-1:0] left;
   logic          hs_q;
   logic [7:0]    pid_q;
   logic          byte_end;

   assign byte_end = (bit_idx == 3'd7);
   assign data_bit = shreg[0];
   assign byte_rd  = consume && byte_end && (left != '0) && !hs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg    <= '0;
         bit_idx  <= '0;
         left     <= '0;
         hs_q     <= 1'b0;
         pid_q    <= '0;
         all_sent <= 1'b0;
      end else if (load) begin
         shreg    <= SYNC_BYTE;
         bit_idx  <= '0;
         left     <= left_init;
         hs_q     <= hs;
         pid_q    <= pid;
         all_sent <= 1'b0;
      end else if (consume) begin
         if (byte_end) begin
            bit_idx <= '0;
            if (left != '0) begin
               left  <= left - 1'b1;
               shreg <= hs_q ? pid_q : byte_data;
            end else begin
               all_sent <= 1'b1;
            end
         end else begin
            shreg   <= {1'b0, shreg[7:1]};
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ls_pkt_tx.sv
module ls_pkt_tx #(
   parameter int CLKS_PER_BIT = 11,
   parameter int MAX_BYTES    = 12,
   parameter int ADDR_W       = 7,
   parameter int SE0_BITS     = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic [$clog2(MAX_BYTES+1)-1:0] byte_cnt,
   input  logic                           hs_mode,
   input  logic                           hs_nak,
   output logic                           byte_rd,
   input  logic [7:0]                     byte_data,
   input  logic [ADDR_W-1:0]              new_addr,
   output logic [ADDR_W:0]                dev_addr,
   output logic                           dp,
   output logic                           dm,
   output logic                           oe,
   output logic                           busy,
   output logic                           done,
   output logic                           rx_clr
);
   import ls_tx_pkg::*;

   localparam int CW = $clog2(MAX_BYTES + 1);
   localparam int SW = (SE0_BITS > 1) ? $clog2(SE0_BITS) : 1;
   localparam logic [CW-1:0] CNT_MIN = CW'(2);
   localparam logic [CW-1:0] CNT_MAX = CW'(MAX_BYTES);

   if (CLKS_PER_BIT < 4) begin : g_bad_clks
      $error("CLKS_PER_BIT must be at least 4");
   end
   if (MAX_BYTES < 2) begin : g_bad_bytes
      $error("MAX_BYTES must be at least 2");
   end
   if (SE0_BITS < 1) begin : g_bad_se0
      $error("SE0_BITS must be at least 1");
   end

   tx_state_e     st;
   logic [SW-1:0] se0_n;
   logic          is_data;
   logic          tick, run;
   logic          step, consume, load;
   logic          stuff_due, line_k, data_bit, all_sent;
   logic          last_slot;
   logic [CW-1:0] n_eff, left_init;
   logic [7:0]    pid_sel;

   assign load      = (st == ST_IDLE) && start;
   assign run       = (st == ST_BITS) || (st == ST_SE0) || (st == ST_JEND);
   assign last_slot = all_sent && !stuff_due;
   assign step      = (st == ST_PRESET) || ((st == ST_BITS) && tick && !last_slot);
   assign consume   = step && !stuff_due;

   always_comb begin
      if (byte_cnt < CNT_MIN)      n_eff = CNT_MIN;
      else if (byte_cnt > CNT_MAX) n_eff = CNT_MAX;
      else                         n_eff = byte_cnt;
   end
   assign left_init = hs_mode ? CW'(1) : (n_eff - 1'b1);
   assign pid_sel   = hs_nak ? PID_NAK : PID_ACK;

   ls_tx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   ls_tx_byte_feed #(.MAX_BYTES(MAX_BYTES)) u_feed (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .hs        (hs_mode),
      .pid       (pid_sel),
      .left_init (left_init),
      .consume   (consume),
      .byte_data (byte_data),
      .data_bit  (data_bit),
      .all_sent  (all_sent),
      .byte_rd   (byte_rd)
   );

   ls_tx_line_coder #(.RUN_LEN(STUFF_RUN)) u_coder (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (load),
      .step      (step),
      .data_bit  (data_bit),
      .stuff_due (stuff_due),
      .line_k    (line_k)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         se0_n    <= '0;
         is_data  <= 1'b0;
         done     <= 1'b0;
         rx_clr   <= 1'b0;
         dev_addr <= '0;
      end else begin
         done   <= 1'b0;
         rx_clr <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st      <= ST_PRESET;
                  is_data <= !hs_mode;
               end
            end
            ST_PRESET: st <= ST_BITS;
            ST_BITS: begin
               if (tick && last_slot) begin
                  st    <= ST_SE0;
                  se0_n <= '0;
               end
            end
            ST_SE0: begin
               if (tick) begin
                  if (se0_n == SW'(SE0_BITS - 1)) st <= ST_JEND;
                  else                            se0_n <= se0_n + 1'b1;
               end
            end
            ST_JEND: begin
               if (tick) begin
                  st     <= ST_IDLE;
                  done   <= 1'b1;
                  rx_clr <= 1'b1;
                  if (is_data) dev_addr <= {new_addr, 1'b0};
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      dp = 1'b0;
      dm = 1'b0;
      oe = 1'b0;
      case (st)
         ST_PRESET: dm = 1'b1;
         ST_BITS: begin
            oe = 1'b1;
            dp = line_k;
            dm = !line_k;
         end
         ST_SE0: oe = 1'b1;
         ST_JEND: begin
            oe = 1'b1;
            dm = 1'b1;
         end
         default: ;
      endcase
   end

   assign busy = (st != ST_IDLE);
endmodule

// File: rtl/ls_pkt_tx_chk.sv
module ls_pkt_tx_chk #(
   parameter int ADDR_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            rx_clr,
   input logic            oe,
   input logic            dp,
   input logic            dm,
   input logic            byte_rd,
   input logic [ADDR_W:0] dev_addr
);
   // R2
   preset_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> ($past(dm) && !$past(dp)));

   // R4
   no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dp && dm));

   // R8
   release_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe) |-> ($past(dm) && !$past(dp)));

   // R8
   idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe && !busy) |-> (!dp && !dm));

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && rx_clr && !oe));

   // R10
   addr_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_addr) |-> done);

   // R7
   fetch_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_rd |-> (busy && oe));
endmodule

bind ls_pkt_tx ls_pkt_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .rx_clr   (rx_clr),
   .oe       (oe),
   .dp       (dp),
   .dm       (dm),
   .byte_rd  (byte_rd),
   .dev_addr (dev_addr)
);

// File: tb/ls_pkt_tx_bench.sv
module ls_pkt_tx_bench;
   localparam int CLK_P = 10;
   localparam int C     = 11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] byte_cnt = '0;
   logic       hs_mode = 1'b0;
   logic       hs_nak = 1'b0;
   logic       byte_rd;
   logic [7:0] byte_data;
   logic [6:0] new_addr = '0;
   logic [7:0] dev_addr;
   logic       dp, dm, oe, busy, done, rx_clr;

   logic [7:0] mem [0:15];
   int         rd_idx = 0;
   logic       clr_rd = 1'b0;
   int         checks = 0;
   int         errors = 0;
   bit         finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   assign byte_data = mem[rd_idx[3:0]];
   always @(posedge clk) begin
      if (clr_rd)       rd_idx <= 0;
      else if (byte_rd) rd_idx <= rd_idx + 1;
   end

   ls_pkt_tx u_ls_pkt_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
      .hs_mode(hs_mode), .hs_nak(hs_nak), .byte_rd(byte_rd),
      .byte_data(byte_data), .new_addr(new_addr), .dev_addr(dev_addr),
      .dp(dp), .dm(dm), .oe(oe), .busy(busy), .done(done), .rx_clr(rx_clr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_and_check(input bit hs, input bit nak, input int cnt_req,
                                 input logic [6:0] addr, input bit poke);
      int n, nb, ones, lvl_now, i, bad_bits, bad_eop, first_bad;
      int lvl [0:159];
      logic [7:0] eb [0:15];
      logic [7:0] prev_addr;
      int exp_code, act_code, total;
      n = hs ? 2 : (cnt_req < 2 ? 2 : (cnt_req > 12 ? 12 : cnt_req));
      eb[0] = 8'h80;
      if (hs) eb[1] = nak ? 8'h5A : 8'hD2;
      else for (int k = 1; k < n; k++) eb[k] = mem[k-1];
      nb = 0; ones = 0; lvl_now = 0;
      for (int b = 0; b < n; b++) begin
         for (int j = 0; j < 8; j++) begin
            if (eb[b][j]) ones++;
            else begin ones = 0; lvl_now ^= 1; end
            lvl[nb] = lvl_now; nb++;
            if (ones == 6) begin
               ones = 0; lvl_now ^= 1; lvl[nb] = lvl_now; nb++;
            end
         end
      end
      prev_addr = dev_addr;
      @(negedge clk); clr_rd = 1'b1;
      @(negedge clk); clr_rd = 1'b0;
      start = 1'b1; byte_cnt = 4'(cnt_req); hs_mode = hs; hs_nak = nak; new_addr = addr;
      @(negedge clk); start = 1'b0;
      // R2 preset J with drivers still off
      chk(oe == 1'b0 && dm == 1'b1 && dp == 1'b0 && busy == 1'b1, "R2 preset",
          int'({busy, oe, dp, dm}), 4'b1001);
      @(negedge clk);
      // R3 first driven bit is K
      chk(oe && dp && !dm, "R3 first bit K", int'({oe, dp, dm}), 3'b110);
      i = 0; bad_bits = 0; bad_eop = 0; first_bad = -1;
      while (oe === 1'b1 && i < 5000) begin
         act_code = int'({oe, dp, dm});
         if (i < nb * C) exp_code = lvl[i / C] ? 3'b110 : 3'b101;
         else if (i < (nb + 2) * C) exp_code = 3'b100;
         else exp_code = 3'b101;
         if (act_code != exp_code) begin
            if (i < nb * C) bad_bits++; else bad_eop++;
            if (first_bad < 0) first_bad = i;
         end
         if (poke && i == 40) begin start = 1'b1; hs_mode = ~hs; end
         else start = 1'b0;
         i++;
         @(negedge clk);
      end
      start = 1'b0;
      total = (nb + 3) * C;
      // R4 R5 data bit levels including stuffing
      chk(bad_bits == 0, "R4 R5 bit trace", first_bad, -1);
      // R8 SE0 then J
      chk(bad_eop == 0, "R8 eop trace", first_bad, -1);
      // R6 duration of every bit slot
      chk(i == total, "R6 R8 packet length", i, total);
      // R11 release pulses, R8 lines released
      chk(done && rx_clr && !busy && !dp && !dm && !oe, "R11 R8 release",
          int'({done, rx_clr, busy, dp, dm, oe}), 6'b110000);
      // R7 R9 fetch count
      chk(rd_idx == (hs ? 0 : n - 1), "R7 R9 fetch count", rd_idx, hs ? 0 : n - 1);
      // R10 address commit
      if (hs) chk(dev_addr == prev_addr, "R10 hs keeps addr", dev_addr, prev_addr);
      else    chk(dev_addr == {addr, 1'b0}, "R10 data commits addr", dev_addr, {addr, 1'b0});
      @(negedge clk);
      chk(!done && !rx_clr, "R11 single pulse", int'({done, rx_clr}), 0);
   endtask

   task automatic t_reset();
      // R1
      chk(!oe && !dp && !dm && !busy && !done && !rx_clr, "R1 reset",
          int'({oe, dp, dm, busy, done, rx_clr}), 0);
   endtask

   task automatic t_basic();
      mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h00;
      send_and_check(1'b0, 1'b0, 4, 7'h15, 1'b0);
   endtask

   task automatic t_stuff_cross();
      // R5 run of ones spanning a byte boundary
      mem[0] = 8'hE0; mem[1] = 8'h07; mem[2] = 8'hFF; mem[3] = 8'hFF;
      send_and_check(1'b0, 1'b0, 5, 7'h2A, 1'b0);
   endtask

   task automatic t_stuff_end();
      // R5 stuffed bit after the final bit
      mem[0] = 8'h12; mem[1] = 8'hFC;
      send_and_check(1'b0, 1'b0, 3, 7'h33, 1'b0);
   endtask

   task automatic t_hs_ack();
      send_and_check(1'b1, 1'b0, 7, 7'h01, 1'b0);
   endtask

   task automatic t_hs_nak();
      send_and_check(1'b1, 1'b1, 2, 7'h7F, 1'b0);
   endtask

   task automatic t_max();
      for (int k = 0; k < 16; k++) mem[k] = 8'(k * 37 + 5);
      send_and_check(1'b0, 1'b0, 12, 7'h44, 1'b0);
   endtask

   task automatic t_clamp_low();
      mem[0] = 8'h69;
      send_and_check(1'b0, 1'b0, 0, 7'h0C, 1'b0);
   endtask

   task automatic t_clamp_high();
      for (int k = 0; k < 16; k++) mem[k] = 8'(8'hFF - k);
      send_and_check(1'b0, 1'b0, 15, 7'h5B, 1'b0);
   endtask

   task automatic t_busy_ignore();
      // R11 start while busy has no effect
      mem[0] = 8'h81; mem[1] = 8'h7E;
      send_and_check(1'b0, 1'b0, 3, 7'h21, 1'b1);
      chk(!busy, "R11 no restart", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_stuff_cross();
      t_stuff_end();
      t_hs_ack();
      t_hs_nak();
      t_max();
      t_clamp_low();
      t_clamp_high();
      t_busy_ignore();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule